// File: doc/BRIEF.md
# Dual Edge-Selectable Event Counter Pair

This block counts transitions on two asynchronous event inputs. Each input first passes through a two-flop synchroniser into the system clock domain. A digital edge detector then turns every qualifying transition into a one-cycle pulse. Each input has its own edge select, so it can count either rising or falling transitions. Each pulse advances a 16-bit counter by one, and the counter wraps to zero after its maximum value.

A host reaches the block through a byte-wide register port. The port has a write strobe, an address, write data and a combinational read-data output. One control byte holds the two edge selects and a cascade bit. When the cascade bit is set, the two counters form one 32-bit counter. The first input advances the low half. The high half advances only when the low half wraps, and the second input is ignored. The host can also preset any single counter byte. A preset takes priority over an event that arrives in the same clock cycle.

Top module: `evt_counter_pair`

## Requirements
- R1: After reset both counters read 0000h, and the control byte reads 00h (both inputs count falling edges, cascade off).
- R2: The control byte is at address 0Ch. Bit 0 is the edge select of input A, bit 1 is the edge select of input B, and bit 2 is the cascade bit. Bits 7..3 always read as 0.
- R3: With its edge-select bit at 1, counter A adds exactly one per rising transition of input A. With the bit at 0, it adds one per falling transition. The opposite transition leaves the counter unchanged.
- R4: Counter B follows input B and its own edge select in the same way, independently of counter A when cascade is off.
- R5: A qualifying transition of an input, applied between clock edges, shows on the read data after the third rising clock edge, not after the second.
- R6: With cascade off, a counter at FFFFh that receives one counting edge becomes 0000h.
- R7: With cascade on, counter A holds the low half and counter B the high half. Counter B adds one exactly when counter A wraps from FFFFh to 0000h. Transitions on input B change nothing.
- R8: Counter bytes are little-endian: 0Dh is A low, 0Eh is A high, 0Fh is B low, and 10h is B high. A write to one of these addresses presets that byte only.
- R9: When a host write to a byte of a counter falls in the same clock cycle as a counting pulse for that counter, the written value is kept and that event is dropped.
- R10: Addresses other than 0Ch..10h read as 00h, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_a_i | input | 1 | Asynchronous event input A |
| evt_b_i | input | 1 | Asynchronous event input B |
| reg_we_i | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr_i | input | 5 | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |

## Verification
An event applied between clock edges takes three rising edges to reach a counter: two synchroniser flops, then the counter register. The bench drives each input on a falling edge and checks once after the second rising edge, where the old value must remain, and once after the third, where the new value is due. Between events it waits four cycles. A register write takes effect at the first rising edge, and read data follows the address within the same cycle. Reads are therefore taken a fraction of a nanosecond after a falling edge. The collision case raises the write strobe exactly in the cycle that holds the edge pulse, which is two falling edges after the input changes.

// File: rtl/evtc_pkg.sv
`timescale 1ns/1ps
package evtc_pkg;

   localparam int NUM_CH = 2;   // two counters share one register port

   typedef struct packed {
      logic cascade;
      logic edge_b;             // 1: rising, 0: falling
      logic edge_a;
   } evtc_ctrl_t;

   localparam int CTRL_BITS = $bits(evtc_ctrl_t);

endpackage

// File: rtl/evtc_edge_det.sv
`timescale 1ns/1ps
// Synchroniser chain followed by a one-cycle edge pulse of selectable polarity.
module evtc_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rise_sel_i,
   output logic pulse_o
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evtc_edge_det: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], evt_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   logic now_lvl;
   assign now_lvl = sync_q[STAGES-1];

   always_comb begin
      if (rise_sel_i) pulse_o = now_lvl & ~last_q;
      else            pulse_o = ~now_lvl & last_q;
   end

endmodule

// File: rtl/evtc_counter.sv
`timescale 1ns/1ps
// One counter with byte-granular preset; a preset suppresses the increment.
module evtc_counter #(
   parameter int W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc_i,
   input  logic [W/8-1:0]  wr_sel_i,
   input  logic [7:0]      wr_byte_i,
   output logic [W-1:0]    q_o,
   output logic            wrap_o
);

   localparam int NB = W / 8;

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nxt;
   logic         wr_any;

   assign wr_any = |wr_sel_i;

   always_comb begin
      cnt_nxt = cnt_q;
      if (wr_any) begin
         for (int k = 0; k < NB; k++) begin
            if (wr_sel_i[k]) cnt_nxt[k*8 +: 8] = wr_byte_i;
         end
      end else if (inc_i) begin
         cnt_nxt = cnt_q + W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign q_o    = cnt_q;
   assign wrap_o = inc_i & ~wr_any & (&cnt_q);

endmodule

// File: rtl/evtc_regmap.sv
`timescale 1ns/1ps
// Control byte, write decode for counter bytes, and read multiplexer.
module evtc_regmap
   import evtc_pkg::*;
#(
   parameter int W         = 16,
   parameter int ADDR_W    = 5,
   parameter int CTRL_ADDR = 12,
   parameter int CNT_BASE  = 13
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [7:0]               wdata_i,
   input  logic [NUM_CH*W-1:0]      cnt_flat_i,
   output evtc_ctrl_t               ctrl_o,
   output logic [NUM_CH*W/8-1:0]    wr_sel_o,
   output logic [7:0]               rdata_o
);

   localparam int NB = W / 8;

   evtc_ctrl_t ctrl_q;
   logic       ctrl_hit;

   assign ctrl_hit = (addr_i == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n)                ctrl_q <= '0;
      else if (we_i && ctrl_hit) ctrl_q <= wdata_i[CTRL_BITS-1:0];
   end

   assign ctrl_o = ctrl_q;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         for (genvar k = 0; k < NB; k++) begin : g_byte
            assign wr_sel_o[c*NB + k] =
               we_i && (addr_i == ADDR_W'(CNT_BASE + c*NB + k));
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (ctrl_hit) rdata_o = {{(8-CTRL_BITS){1'b0}}, ctrl_q};
      for (int i = 0; i < NUM_CH*NB; i++) begin
         if (addr_i == ADDR_W'(CNT_BASE + i)) rdata_o = cnt_flat_i[i*8 +: 8];
      end
   end

endmodule

// File: rtl/evt_counter_pair.sv
`timescale 1ns/1ps
module evt_counter_pair
   import evtc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 5,
   parameter int CTRL_ADDR   = 12,
   parameter int CNT_BASE    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_a_i,
   input  logic              evt_b_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [7:0]        reg_wdata_i,
   output logic [7:0]        reg_rdata_o
);

   localparam int NB = CNT_W / 8;

   generate
      if (CNT_W < 8 || (CNT_W % 8) != 0) begin : g_bad_width
         $error("evt_counter_pair: CNT_W must be a positive multiple of 8");
      end
      if (CNT_BASE + NUM_CH*NB > (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("evt_counter_pair: register map exceeds address space");
      end
      if (CTRL_ADDR >= CNT_BASE && CTRL_ADDR < CNT_BASE + NUM_CH*NB) begin : g_overlap
         $error("evt_counter_pair: control byte overlaps counter bytes");
      end
   endgenerate

   evtc_ctrl_t          ctrl;
   logic [NUM_CH-1:0]   evt_in;
   logic [NUM_CH-1:0]   rise_sel;
   logic [NUM_CH-1:0]   pulse;
   logic [NUM_CH-1:0]   inc;
   logic [NUM_CH-1:0]   wrap;
   logic [CNT_W-1:0]    cnt_q [NUM_CH];
   logic [NUM_CH*CNT_W-1:0] cnt_flat;
   logic [NUM_CH*NB-1:0]    wr_sel;

   assign evt_in   = {evt_b_i, evt_a_i};
   assign rise_sel = {ctrl.edge_b, ctrl.edge_a};

   // Channel 1 takes its increment from channel 0's wrap when cascaded.
   assign inc[0] = pulse[0];
   assign inc[1] = ctrl.cascade ? wrap[0] : pulse[1];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         evtc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_in[c]),
            .rise_sel_i (rise_sel[c]),
            .pulse_o    (pulse[c])
         );

         evtc_counter #(.W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc[c]),
            .wr_sel_i  (wr_sel[c*NB +: NB]),
            .wr_byte_i (reg_wdata_i),
            .q_o       (cnt_q[c]),
            .wrap_o    (wrap[c])
         );

         assign cnt_flat[c*CNT_W +: CNT_W] = cnt_q[c];
      end
   endgenerate

   evtc_regmap #(
      .W         (CNT_W),
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .CNT_BASE  (CNT_BASE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (reg_we_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .cnt_flat_i (cnt_flat),
      .ctrl_o     (ctrl),
      .wr_sel_o   (wr_sel),
      .rdata_o    (reg_rdata_o)
   );

endmodule

// File: rtl/evtc_checker.sv
`timescale 1ns/1ps
module evtc_checker #(
   parameter int W         = 16,
   parameter int ADDR_W    = 5,
   parameter int CTRL_ADDR = 12,
   parameter int CNT_BASE  = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic [W-1:0]      cnt_a,
   input logic [W-1:0]      cnt_b,
   input logic              cascade,
   input logic              pulse_a,
   input logic              pulse_b
);

   localparam int NB = W / 8;

   logic hit_a, hit_b, mapped;
   assign hit_a  = we && (int'(addr) >= CNT_BASE) && (int'(addr) < CNT_BASE + NB);
   assign hit_b  = we && (int'(addr) >= CNT_BASE + NB) && (int'(addr) < CNT_BASE + 2*NB);
   assign mapped = (int'(addr) == CTRL_ADDR) ||
                   ((int'(addr) >= CNT_BASE) && (int'(addr) < CNT_BASE + 2*NB));

   assert_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (cnt_a == '0 && cnt_b == '0 && !cascade));

   assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr) == CTRL_ADDR) |-> (rdata[7:3] == 5'd0));

   assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_a |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + W'(1)));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade && pulse_b && (&cnt_b) && !hit_b) |=> (cnt_b == '0));

   assert_cascade_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade && !hit_b && !(pulse_a && (&cnt_a) && !hit_a)) |=> $stable(cnt_b));

   assert_cascade_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade && pulse_a && (&cnt_a) && !hit_a && !hit_b) |=> (cnt_b == $past(cnt_b) + W'(1)));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(addr) == CNT_BASE) |=> (cnt_a[7:0] == $past(wdata)));

   assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (rdata == 8'h00));

endmodule

bind evt_counter_pair evtc_checker #(
   .W         (CNT_W),
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (CTRL_ADDR),
   .CNT_BASE  (CNT_BASE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .we      (reg_we_i),
   .addr    (reg_addr_i),
   .wdata   (reg_wdata_i),
   .rdata   (reg_rdata_o),
   .cnt_a   (cnt_q[0]),
   .cnt_b   (cnt_q[1]),
   .cascade (ctrl.cascade),
   .pulse_a (pulse[0]),
   .pulse_b (pulse[1])
);

// File: tb/test_evt_counter_pair.sv
`timescale 1ns/1ps
module test_evt_counter_pair;

   localparam logic [4:0] A_CTRL = 5'h0C;
   localparam logic [4:0] A_ALO  = 5'h0D;
   localparam logic [4:0] A_AHI  = 5'h0E;
   localparam logic [4:0] A_BLO  = 5'h0F;
   localparam logic [4:0] A_BHI  = 5'h10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ea = 1'b0, eb = 1'b0;
   logic       we = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;   // 250 MHz

   evt_counter_pair i_evt_counter_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_a_i     (ea),
      .evt_b_i     (eb),
      .reg_we_i    (we),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd8(input logic [4:0] a, output logic [7:0] d);
      addr = a;
      #0.4;
      d = rdata;
   endtask

   task automatic rd16(input logic [4:0] lo, output logic [15:0] v);
      logic [7:0] l, h;
      @(negedge clk);
      rd8(lo, l);
      rd8(lo + 5'd1, h);
      v = {h, l};
   endtask

   task automatic set_evt(input int ch, input logic v);
      @(negedge clk);
      if (ch == 0) ea = v; else eb = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [15:0] v; logic [7:0] c;
      rd16(A_ALO, v); chk("R1 counter A after reset", v, 16'h0000);
      rd16(A_BLO, v); chk("R1 counter B after reset", v, 16'h0000);
      @(negedge clk); rd8(A_CTRL, c); chk("R1 control after reset", c, 8'h00);
   endtask

   task automatic t_ctrl;
      logic [7:0] c;
      wr(A_CTRL, 8'hFF);
      @(negedge clk); rd8(A_CTRL, c); chk("R2 control reads only 3 bits", c, 8'h07);
      wr(A_CTRL, 8'h00);
      @(negedge clk); rd8(A_CTRL, c); chk("R2 control cleared", c, 8'h00);
   endtask

   task automatic t_count_a;
      logic [15:0] v;
      for (int i = 0; i < 3; i++) begin
         set_evt(0, 1'b1);
         set_evt(0, 1'b0);
      end
      rd16(A_ALO, v); chk("R3 three falling edges on A", v, 16'd3);
      wr(A_CTRL, 8'h01);
      set_evt(0, 1'b1);
      rd16(A_ALO, v); chk("R3 rising edge counted", v, 16'd4);
      set_evt(0, 1'b0);
      rd16(A_ALO, v); chk("R3 falling edge ignored in rising mode", v, 16'd4);
   endtask

   task automatic t_latency;
      logic [15:0] v;
      @(negedge clk); ea = 1'b1;
      @(negedge clk); @(negedge clk);
      rd8(A_ALO, v[7:0]); chk("R5 not yet after two edges", v[7:0], 8'd4);
      @(negedge clk);
      rd8(A_ALO, v[7:0]); chk("R5 counted after third edge", v[7:0], 8'd5);
      set_evt(0, 1'b0);
   endtask

   task automatic t_indep_b;
      logic [15:0] v;
      wr(A_CTRL, 8'h03);
      set_evt(1, 1'b1);
      set_evt(1, 1'b0);
      set_evt(1, 1'b1);
      rd16(A_BLO, v); chk("R4 two rising edges on B", v, 16'd2);
      rd16(A_ALO, v); chk("R4 counter A unaffected by B", v, 16'd5);
      set_evt(1, 1'b0);
   endtask

   task automatic t_preset;
      logic [15:0] v;
      wr(A_AHI, 8'hAB);
      rd16(A_ALO, v); chk("R8 high byte preset alone", v, 16'hAB05);
      wr(A_ALO, 8'h3C);
      rd16(A_ALO, v); chk("R8 low byte preset alone", v, 16'hAB3C);
      rd16(A_BLO, v); chk("R8 counter B untouched by A writes", v, 16'd2);
   endtask

   task automatic t_wrap;
      logic [15:0] v;
      wr(A_BLO, 8'hFF); wr(A_BHI, 8'hFF);
      rd16(A_BLO, v); chk("R8 counter B preset to FFFF", v, 16'hFFFF);
      set_evt(1, 1'b1);
      rd16(A_BLO, v); chk("R6 counter B wraps to zero", v, 16'h0000);
      set_evt(1, 1'b0);
   endtask

   task automatic t_cascade;
      logic [15:0] v;
      wr(A_CTRL, 8'h05);
      wr(A_ALO, 8'hFF); wr(A_AHI, 8'hFF);
      wr(A_BLO, 8'h12); wr(A_BHI, 8'h00);
      set_evt(0, 1'b1);
      rd16(A_ALO, v); chk("R7 low half wrapped", v, 16'h0000);
      rd16(A_BLO, v); chk("R7 high half carried", v, 16'h0013);
      set_evt(0, 1'b0);
      set_evt(0, 1'b1);
      rd16(A_ALO, v); chk("R7 low half counts", v, 16'h0001);
      rd16(A_BLO, v); chk("R7 no carry without wrap", v, 16'h0013);
      set_evt(1, 1'b1); set_evt(1, 1'b0); set_evt(1, 1'b1); set_evt(1, 1'b0);
      rd16(A_BLO, v); chk("R7 input B ignored in cascade", v, 16'h0013);
      set_evt(0, 1'b0);
      wr(A_CTRL, 8'h01);
   endtask

   task automatic t_collision;
      logic [15:0] v;
      wr(A_ALO, 8'h03); wr(A_AHI, 8'h00);
      @(negedge clk); ea = 1'b1;
      @(negedge clk);
      @(negedge clk);
      we = 1'b1; addr = A_ALO; wdata = 8'h55;
      @(negedge clk);
      we = 1'b0;
      repeat (3) @(negedge clk);
      rd16(A_ALO, v); chk("R9 write wins over same-cycle edge", v, 16'h0055);
      set_evt(0, 1'b0);
   endtask

   task automatic t_unmapped;
      logic [7:0] d; logic [15:0] v;
      @(negedge clk); rd8(5'h00, d); chk("R10 address 00h reads zero", d, 8'h00);
      rd8(5'h11, d); chk("R10 address 11h reads zero", d, 8'h00);
      wr(5'h11, 8'hEE); wr(5'h0B, 8'hEE);
      rd16(A_ALO, v); chk("R10 stray writes leave A", v, 16'h0055);
      rd16(A_BLO, v); chk("R10 stray writes leave B", v, 16'h0013);
      @(negedge clk); rd8(A_CTRL, d); chk("R10 stray writes leave control", d, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_count_a();
      t_latency();
      t_indep_b();
      t_preset();
      t_wrap();
      t_cascade();
      t_collision();
      t_unmapped();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule